// File: doc/BRIEF.md
# Byte-Addressed GPIO and Machine Timer Window

This block is a small peripheral window that sits beside the RAM of a compact RISC-V style controller. A base address, supplied from a configuration register outside the block, places a 256-byte window in the address map. The first eighteen bytes of the window hold the following registers:

- a four-bit pin direction register;
- a four-bit pin data register;
- a free-running 64-bit time counter;
- a 64-bit compare value.

The rest of the window is reserved. When the time counter reaches the compare value, the block raises a pending flag for the interrupt logic.

The requester issues byte-enabled accesses up to four bytes wide, and each enabled byte lane is decoded on its own. A single access may therefore straddle several registers. A mode input reverses the byte order inside the two 64-bit registers. Read data is combinational from the request. Writes take effect at the next clock edge.

The block also flags accesses that fall above RAM and outside the window as load or store access faults. A base address of zero switches the whole window off.

Top module: `pio_timer_window`

## Requirements
- R1: Relative to the base, offset 0 is the direction register, offset 1 the data register, offsets 2..9 the time counter and offsets 10..17 the compare value. Lane k of an access addresses req_addr+k.
- R2: With base_addr equal to zero, no address decodes as a register. Reads return zero and writes change nothing.
- R3: Each lane whose req_be bit is set is decoded separately. A read returns the addressed byte in rd_data bits 8k+7..8k. Lanes that are disabled or unmatched read zero and never write.
- R4: Within the time counter and the compare value, the byte index is the offset minus the register start when big_endian is 0. It is 7 minus that value when big_endian is 1.
- R5: pin_out carries the latched data register and pin_oe carries the direction register (1 = output). A data read returns latched bits where the direction bit is 1 and pin_in where it is 0.
- R6: A data write changes only bits whose direction is 1. The direction used is the value after any direction byte written in the same access.
- R7: A write of one byte of the time counter or the compare value replaces that byte only. The other seven bytes are unchanged.
- R8: tmr_pending is 1 exactly when the time counter is greater than or equal to the compare value, both taken as 64-bit unsigned numbers.
- R9: Each cycle with tick_en high adds one to the time counter, with the carry passing from bit 31 into bit 32. If a counter byte is written in the same cycle, that byte takes the written value and the other bytes take the incremented value.
- R10: Offsets 18..255 read zero, ignore writes and raise no fault.
- R11: After reset all registers are zero, pin_out and pin_oe are 0, and tmr_pending is 1.
- R12: While req_valid is high, an enabled lane at an address of at least RAM_BYTES that is outside the window raises ld_fault (read) or st_fault (write).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Time counter increment enable |
| base_addr | input | ADDR_W | Window base address, zero disables |
| big_endian | input | 1 | Reverse byte order in 64-bit registers |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Address of lane 0 |
| req_be | input | LANES | Byte lane enables |
| req_wdata | input | 8*LANES | Write data, lane k in bits 8k+7..8k |
| rd_data | output | 8*LANES | Read data, combinational |
| ld_fault | output | 1 | Load access fault |
| st_fault | output | 1 | Store access fault |
| pin_in | input | PIN_W | Pin levels |
| pin_out | output | PIN_W | Latched output values |
| pin_oe | output | PIN_W | Pin output enables |
| tmr_pending | output | 1 | Time counter has reached compare value |

## Verification
Two pairs of operations can act in the same cycle.

The first pair is the tick increment and a software write to a counter byte. The bench sets the low counter byte to 0xFF. It then raises tick_en in the same cycle as a write to byte 1. The check is that the carry into byte 1 is lost to the written value while byte 0 wraps to zero.

The second pair is a direction write and a data write in one two-lane access. The bench judges the latched data against a mask built from the new direction rather than the old one.

Carry across the 32-bit boundary and equality of counter and compare value are also driven on purpose.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int TMR_BYTES = 8;
  localparam int TMR_W     = 8 * TMR_BYTES;
  localparam int IDX_W     = $clog2(TMR_BYTES);
  localparam int OFF_DIR   = 0;
  localparam int OFF_DATA  = 1;
  localparam int OFF_CNT   = 2;
  localparam int OFF_CMP   = OFF_CNT + TMR_BYTES;
  localparam int OFF_END   = OFF_CMP + TMR_BYTES;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DIR,
    SEL_DATA,
    SEL_CNT,
    SEL_CMP
  } sel_e;
endpackage

// File: rtl/ptw_rst_sync.sv
module ptw_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      meta_q    <= 1'b0;
      rst_n_out <= 1'b0;
    end else begin
      meta_q    <= 1'b1;
      rst_n_out <= meta_q;
    end
  end
endmodule

// File: rtl/ptw_lane_dec.sv
module ptw_lane_dec
  import ptw_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int WIN_BYTES = 256
) (
  input  logic [ADDR_W-1:0] lane_addr,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              big_endian,
  output logic              in_win,
  output sel_e              sel,
  output logic [IDX_W-1:0]  bidx
);
  logic [ADDR_W-1:0] off;
  logic [IDX_W-1:0]  raw;

  always_comb begin
    off    = lane_addr - base_addr;
    in_win = (base_addr != '0) && (lane_addr >= base_addr) &&
             (off < ADDR_W'(WIN_BYTES));
    sel    = SEL_NONE;
    raw    = '0;
    if (in_win) begin
      if (off == ADDR_W'(OFF_DIR)) begin
        sel = SEL_DIR;
      end else if (off == ADDR_W'(OFF_DATA)) begin
        sel = SEL_DATA;
      end else if (off < ADDR_W'(OFF_CMP)) begin
        sel = SEL_CNT;
        raw = IDX_W'(off - ADDR_W'(OFF_CNT));
      end else if (off < ADDR_W'(OFF_END)) begin
        sel = SEL_CMP;
        raw = IDX_W'(off - ADDR_W'(OFF_CMP));
      end
    end
    bidx = big_endian ? (IDX_W'(TMR_BYTES - 1) - raw) : raw;
  end
endmodule

// File: rtl/ptw_gpio.sv
module ptw_gpio #(
  parameter int PIN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dir_we,
  input  logic [PIN_W-1:0] dir_wd,
  input  logic             dat_we,
  input  logic [PIN_W-1:0] dat_wd,
  input  logic [PIN_W-1:0] pin_in,
  output logic [PIN_W-1:0] dir_q,
  output logic [PIN_W-1:0] dat_q,
  output logic [PIN_W-1:0] dat_rd
);
  logic [PIN_W-1:0] dir_n;
  logic [PIN_W-1:0] dat_n;
  logic             reg_en;

  always_comb begin
    dir_n  = dir_we ? dir_wd : dir_q;
    dat_n  = dat_we ? ((dat_wd & dir_n) | (dat_q & ~dir_n)) : dat_q;
    reg_en = dir_we | dat_we;
    dat_rd = (dat_q & dir_q) | (pin_in & ~dir_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      dat_q <= '0;
    end else if (reg_en) begin
      dir_q <= dir_n;
      dat_q <= dat_n;
    end
  end

  // R6: bits that are inputs after an edge never change their latched value
  assert_input_bits_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((dat_q ^ $past(dat_q)) & ~dir_q) == '0);
endmodule

// File: rtl/ptw_timer.sv
module ptw_timer
  import ptw_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tick_en,
  input  logic [TMR_BYTES-1:0]      cnt_we,
  input  logic [TMR_BYTES-1:0][7:0] cnt_wd,
  input  logic [TMR_BYTES-1:0]      cmp_we,
  input  logic [TMR_BYTES-1:0][7:0] cmp_wd,
  output logic [TMR_BYTES-1:0][7:0] cnt_q,
  output logic [TMR_BYTES-1:0][7:0] cmp_q,
  output logic                      pending
);
  localparam int HALF = TMR_W / 2;

  logic [TMR_W-1:0]           cnt_flat;
  logic [TMR_W-1:0]           cmp_flat;
  logic [HALF:0]              lo_sum;
  logic [HALF-1:0]            hi_sum;
  logic [TMR_W-1:0]           inc;
  logic [TMR_BYTES-1:0][7:0]  cnt_n;
  logic [TMR_BYTES-1:0][7:0]  cmp_n;
  logic                       cnt_en;
  logic                       cmp_en;

  assign cnt_flat = cnt_q;
  assign cmp_flat = cmp_q;

  always_comb begin
    lo_sum = {1'b0, cnt_flat[HALF-1:0]} + (HALF+1)'(tick_en);
    hi_sum = cnt_flat[TMR_W-1:HALF] + HALF'(lo_sum[HALF]);
    inc    = {hi_sum, lo_sum[HALF-1:0]};
    for (int b = 0; b < TMR_BYTES; b++) begin
      cnt_n[b] = cnt_we[b] ? cnt_wd[b] : inc[8*b +: 8];
      cmp_n[b] = cmp_we[b] ? cmp_wd[b] : cmp_q[b];
    end
    cnt_en  = tick_en | (|cnt_we);
    cmp_en  = |cmp_we;
    pending = (cnt_flat >= cmp_flat);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '0;
    end else if (cmp_en) begin
      cmp_q <= cmp_n;
    end
  end

  // R9: a tick without a counter write advances the count by exactly one
  assert_tick_adds_one_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && (cnt_we == '0)) |=> (cnt_flat == $past(cnt_flat) + TMR_W'(1)));

  // R7: the compare value only moves when one of its bytes is written
  assert_cmp_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_we == '0) |=> $stable(cmp_flat));

  // R8: with no tick and no writes the pending flag cannot change
  assert_pending_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && (cnt_we == '0) && (cmp_we == '0)) |=> $stable(pending));
endmodule

// File: rtl/pio_timer_window.sv
module pio_timer_window
  import ptw_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LANES     = 4,
  parameter int PIN_W     = 4,
  parameter int WIN_BYTES = 256,
  parameter int RAM_BYTES = 4096
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_en,
  input  logic [ADDR_W-1:0]    base_addr,
  input  logic                 big_endian,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [LANES-1:0]     req_be,
  input  logic [8*LANES-1:0]   req_wdata,
  output logic [8*LANES-1:0]   rd_data,
  output logic                 ld_fault,
  output logic                 st_fault,
  input  logic [PIN_W-1:0]     pin_in,
  output logic [PIN_W-1:0]     pin_out,
  output logic [PIN_W-1:0]     pin_oe,
  output logic                 tmr_pending
);
  localparam int DATA_W = 8 * LANES;

  logic                      rst_ns;
  logic [LANES-1:0]          lane_win;
  sel_e                      lane_sel  [LANES];
  logic [IDX_W-1:0]          lane_idx  [LANES];
  logic [ADDR_W-1:0]         lane_addr [LANES];
  logic [LANES-1:0][7:0]     wbyte;
  logic [LANES-1:0][7:0]     rbyte;
  logic [LANES-1:0]          wr_lane;
  logic [LANES-1:0]          rd_lane;
  logic [LANES-1:0]          miss_lane;

  logic                      dir_we;
  logic                      dat_we;
  logic [PIN_W-1:0]          dir_wd;
  logic [PIN_W-1:0]          dat_wd;
  logic [PIN_W-1:0]          dir_q;
  logic [PIN_W-1:0]          dat_q;
  logic [PIN_W-1:0]          dat_rd;

  logic [TMR_BYTES-1:0]      cnt_we;
  logic [TMR_BYTES-1:0]      cmp_we;
  logic [TMR_BYTES-1:0][7:0] cnt_wd;
  logic [TMR_BYTES-1:0][7:0] cmp_wd;
  logic [TMR_BYTES-1:0][7:0] cnt_q;
  logic [TMR_BYTES-1:0][7:0] cmp_q;

  ptw_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_ns)
  );

  assign wbyte = req_wdata;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_addr[k] = req_addr + ADDR_W'(k);
    ptw_lane_dec #(
      .ADDR_W    (ADDR_W),
      .WIN_BYTES (WIN_BYTES)
    ) u_dec (
      .lane_addr  (lane_addr[k]),
      .base_addr  (base_addr),
      .big_endian (big_endian),
      .in_win     (lane_win[k]),
      .sel        (lane_sel[k]),
      .bidx       (lane_idx[k])
    );
    assign wr_lane[k]   = req_valid & req_write & req_be[k];
    assign rd_lane[k]   = req_valid & ~req_write & req_be[k];
    assign miss_lane[k] = req_be[k] & ~lane_win[k] &
                          (lane_addr[k] >= ADDR_W'(RAM_BYTES));
  end

  // Write steering: gather lane bytes into register byte enables
  always_comb begin
    dir_we = 1'b0;
    dat_we = 1'b0;
    dir_wd = '0;
    dat_wd = '0;
    cnt_we = '0;
    cmp_we = '0;
    cnt_wd = '0;
    cmp_wd = '0;
    for (int k = 0; k < LANES; k++) begin
      if (wr_lane[k]) begin
        case (lane_sel[k])
          SEL_DIR:  begin dir_we = 1'b1; dir_wd = wbyte[k][PIN_W-1:0]; end
          SEL_DATA: begin dat_we = 1'b1; dat_wd = wbyte[k][PIN_W-1:0]; end
          SEL_CNT:  begin cnt_we[lane_idx[k]] = 1'b1; cnt_wd[lane_idx[k]] = wbyte[k]; end
          SEL_CMP:  begin cmp_we[lane_idx[k]] = 1'b1; cmp_wd[lane_idx[k]] = wbyte[k]; end
          default:  ;
        endcase
      end
    end
  end

  // Read steering: each lane returns its own register byte
  always_comb begin
    rbyte = '0;
    for (int k = 0; k < LANES; k++) begin
      if (rd_lane[k]) begin
        case (lane_sel[k])
          SEL_DIR:  rbyte[k] = 8'(dir_q);
          SEL_DATA: rbyte[k] = 8'(dat_rd);
          SEL_CNT:  rbyte[k] = cnt_q[lane_idx[k]];
          SEL_CMP:  rbyte[k] = cmp_q[lane_idx[k]];
          default:  rbyte[k] = 8'h00;
        endcase
      end
    end
  end

  assign rd_data  = DATA_W'(rbyte);
  assign ld_fault = req_valid & ~req_write & (|miss_lane);
  assign st_fault = req_valid &  req_write & (|miss_lane);

  ptw_gpio #(.PIN_W(PIN_W)) u_gpio (
    .clk    (clk),
    .rst_n  (rst_ns),
    .dir_we (dir_we),
    .dir_wd (dir_wd),
    .dat_we (dat_we),
    .dat_wd (dat_wd),
    .pin_in (pin_in),
    .dir_q  (dir_q),
    .dat_q  (dat_q),
    .dat_rd (dat_rd)
  );

  ptw_timer u_tmr (
    .clk     (clk),
    .rst_n   (rst_ns),
    .tick_en (tick_en),
    .cnt_we  (cnt_we),
    .cnt_wd  (cnt_wd),
    .cmp_we  (cmp_we),
    .cmp_wd  (cmp_wd),
    .cnt_q   (cnt_q),
    .cmp_q   (cmp_q),
    .pending (tmr_pending)
  );

  assign pin_out = dat_q;
  assign pin_oe  = dir_q;

  // R2: a zero base address leaves the read bus idle
  assert_zero_base_quiet_R2: assert property (@(posedge clk) disable iff (!rst_ns)
    (base_addr == '0) |-> (rd_data == '0));

  // R6: GPIO registers only move on a request cycle
  assert_gpio_needs_req_R6: assert property (@(posedge clk) disable iff (!rst_ns)
    (!req_valid) |=> ($stable(pin_out) && $stable(pin_oe)));
endmodule

// File: tb/sim_pio_timer_window.sv
`timescale 1ns/1ps
module sim_pio_timer_window;
  localparam logic [31:0] BASE = 32'h0000_8000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic [31:0] base_addr = BASE;
  logic        big_endian = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rd_data;
  logic        ld_fault, st_fault;
  logic [3:0]  pin_in = 4'h0;
  logic [3:0]  pin_out, pin_oe;
  logic        tmr_pending;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pio_timer_window u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .base_addr(base_addr),
    .big_endian(big_endian), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rd_data(rd_data), .ld_fault(ld_fault), .st_fault(st_fault),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .tmr_pending(tmr_pending)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] a, input logic [3:0] be, input logic [31:0] d,
                    input logic tk = 1'b0);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_be = be; req_wdata = d;
    tick_en = tk;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_be = '0; tick_en = 1'b0;
  endtask

  task automatic rd(input logic [31:0] a, input logic [3:0] be,
                    output logic [31:0] d, output logic lf, output logic sf);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_be = be;
    #1;
    d = rd_data; lf = ld_fault; sf = st_fault;
    req_valid = 1'b0; req_be = '0;
  endtask

  task automatic rd64(input int off, output logic [63:0] v);
    logic [31:0] lo, hi;
    logic lf, sf;
    rd(BASE + 32'(off), 4'hF, lo, lf, sf);
    rd(BASE + 32'(off) + 32'd4, 4'hF, hi, lf, sf);
    v = {hi, lo};
  endtask

  task automatic wr64(input int off, input logic [63:0] v);
    wr(BASE + 32'(off), 4'hF, v[31:0]);
    wr(BASE + 32'(off) + 32'd4, 4'hF, v[63:32]);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1'b1;
    end
    @(negedge clk); tick_en = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d; logic lf, sf; logic [63:0] v;
    rd(BASE, 4'h3, d, lf, sf);
    chk("R11 dir/data after reset", 64'(d), 64'h0);
    chk("R11 pin_out/pin_oe after reset", 64'({pin_out, pin_oe}), 64'h0);
    chk("R11 pending after reset", 64'(tmr_pending), 64'h1);
    rd64(2, v);
    chk("R11 counter after reset", v, 64'h0);
  endtask

  task automatic t_gpio;
    logic [31:0] d; logic lf, sf;
    pin_in = 4'hA;
    wr(BASE, 4'h1, 32'h03);
    wr(BASE + 1, 4'h1, 32'h0F);
    chk("R6 data write masked by direction", 64'(pin_out), 64'h3);
    chk("R5 pin_oe follows direction", 64'(pin_oe), 64'h3);
    rd(BASE + 1, 4'h1, d, lf, sf);
    chk("R5 data read mixes pins and latch", 64'(d), 64'h0B);
    wr(BASE, 4'h3, 32'h0F0C);
    chk("R6 same-access direction applies to data", 64'(pin_out), 64'hF);
    rd(BASE + 1, 4'h1, d, lf, sf);
    chk("R5 data read after direction flip", 64'(d), 64'h0E);
  endtask

  task automatic t_order;
    logic [31:0] d; logic lf, sf; logic [63:0] v;
    wr64(2, 64'h8877_6655_4433_2211);
    rd64(2, v);
    chk("R1 counter little-endian readback", v, 64'h8877_6655_4433_2211);
    big_endian = 1'b1;
    rd(BASE + 2, 4'hF, d, lf, sf);
    chk("R4 big-endian first word", 64'(d), 64'h5566_7788);
    rd(BASE + 6, 4'hF, d, lf, sf);
    chk("R4 big-endian second word", 64'(d), 64'h1122_3344);
    big_endian = 1'b0;
    rd(BASE + 3, 4'h5, d, lf, sf);
    chk("R3 sparse lanes", 64'(d), 64'h0044_0022);
    rd(BASE, 4'hF, d, lf, sf);
    chk("R3 access straddling registers", 64'(d), 64'h2211_0E0C);
  endtask

  task automatic t_bytes;
    logic [63:0] v;
    wr(BASE + 12, 4'h1, 32'hAB);
    rd64(10, v);
    chk("R7 single compare byte", v, 64'h0000_0000_00AB_0000);
    big_endian = 1'b1;
    wr(BASE + 10, 4'h1, 32'hCD);
    big_endian = 1'b0;
    rd64(10, v);
    chk("R4 big-endian byte write lands in byte 7", v, 64'hCD00_0000_00AB_0000);
    chk("R8 counter below compare", 64'(tmr_pending), 64'h0);
    wr(BASE + 17, 4'h1, 32'h88);
    chk("R8 counter above compare", 64'(tmr_pending), 64'h1);
    rd64(2, v);
    chk("R7 counter untouched by compare writes", v, 64'h8877_6655_4433_2211);
  endtask

  task automatic t_pending;
    wr64(10, 64'h8877_6655_4433_2211);
    chk("R8 equal values pending", 64'(tmr_pending), 64'h1);
    wr(BASE + 10, 4'h1, 32'h12);
    chk("R8 compare one above", 64'(tmr_pending), 64'h0);
    ticks(1);
    chk("R9 one tick reaches compare", 64'(tmr_pending), 64'h1);
  endtask

  task automatic t_carry;
    logic [63:0] v;
    wr64(2, 64'h0000_0001_FFFF_FFFF);
    ticks(1);
    rd64(2, v);
    chk("R9 carry into upper half", v, 64'h0000_0002_0000_0000);
    wr64(2, 64'h0000_0000_0000_00FF);
    wr(BASE + 3, 4'h1, 32'h22, 1'b1);
    rd64(2, v);
    chk("R9 write beats tick on same byte", v, 64'h0000_0000_0000_2200);
    ticks(5);
    rd64(2, v);
    chk("R9 five ticks", v, 64'h0000_0000_0000_2205);
  endtask

  task automatic t_base_zero;
    logic [31:0] d; logic lf, sf;
    base_addr = '0;
    rd(32'h2, 4'hF, d, lf, sf);
    chk("R2 zero base reads zero", 64'(d), 64'h0);
    wr(32'h0, 4'h3, 32'h0000);
    base_addr = BASE;
    chk("R2 zero base write ignored", 64'({pin_oe, pin_out}), 64'hCF);
  endtask

  task automatic t_reserved_fault;
    logic [31:0] d; logic lf, sf; logic [63:0] v;
    rd(BASE + 18, 4'hF, d, lf, sf);
    chk("R10 reserved read zero", 64'(d), 64'h0);
    chk("R10 reserved no fault", 64'({lf, sf}), 64'h0);
    wr(BASE + 16, 4'hC, 32'hFFFF_0000);
    rd64(10, v);
    chk("R10 reserved write ignored", v, 64'h8877_6655_4433_2212);
    rd(BASE + 252, 4'hF, d, lf, sf);
    chk("R10 window end no fault", 64'({lf, sf}), 64'h0);
    rd(BASE + 253, 4'hF, d, lf, sf);
    chk("R12 lane past window faults", 64'({lf, sf}), 64'h2);
    rd(32'h0000_7000, 4'hF, d, lf, sf);
    chk("R12 load fault above RAM", 64'({lf, sf}), 64'h2);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 32'h0000_7000; req_be = 4'h1;
    #1;
    chk("R12 store fault above RAM", 64'({ld_fault, st_fault}), 64'h1);
    req_valid = 1'b0; req_write = 1'b0; req_be = '0;
    rd(32'h0000_0100, 4'hF, d, lf, sf);
    chk("R12 RAM address no fault", 64'({lf, sf}), 64'h0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_gpio();
    t_order();
    t_bytes();
    t_pending();
    t_carry();
    t_base_zero();
    t_reserved_fault();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule